// File: doc/BRIEF.md
# Parallel Port Byte FIFO with Threshold Interrupts

This block is a sixteen-entry byte queue that sits between a host bus and a parallel port engine. In the forward direction the host fills the queue and the engine drains it. In the reverse direction the engine fills it and the host drains it. Every entry carries one extra tag bit. A host write through the command port sets the tag, which marks the byte as an address or command for the engine. A write through the data port leaves the tag clear.

The host can service the queue with interrupt-driven programmed I/O or with DMA. A five-bit threshold field sets the level at which the interrupt fires, and the meaning of that level depends on the direction. In the reverse direction the interrupt fires once enough bytes are stored. In the forward direction it fires once enough space is free. The DMA request follows simpler level rules. A terminal-count pulse sets a service bit, which silences both the interrupt and the DMA request until software clears the bit.

A host access is a single-cycle strobe on an 11-bit offset. Read data appears on `host_rdata` one clock after the read strobe.

Top module: `ppfifo_ctl`

## Requirements
- R1: The queue holds 16 entries of 9 bits each (tag plus byte) and returns them in first-in first-out order. A push into a full queue is dropped.
- R2: A read at offset 0x401 returns the status byte. Bit 7 is the error flag, bit 6 is full, bit 5 is empty, and bits 4:0 are the occupancy count (0 to 16).
- R3: Offset 0x402 is the readable control byte. Bit 0 is the direction (1 = reverse, engine to host), bit 1 is the DMA enable, bit 2 is the service bit, and bits 7:3 are the threshold. Its reset value is 0x04, and after reset `irq` and `dma_req` are low.
- R4: In the forward direction, host writes to 0x400 push the byte with tag 0 and host writes to 0x000 push it with tag 1. Host reads of 0x400 return 0 and pop nothing. An engine pop presents the byte and tag on `eng_pop_data`/`eng_pop_tag` one clock later. Engine pushes are ignored in this direction.
- R5: In the reverse direction, engine pushes store the byte with tag 0. A host read of 0x400 pops the oldest byte and returns it one clock later, or returns 0 when the queue is empty. Host writes to 0x000/0x400 and engine pops are ignored in this direction.
- R6: With DMA disabled and the service bit clear, in the reverse direction `irq` is high exactly when count >= 16 − T, where T is the effective threshold.
- R7: With DMA disabled and the service bit clear, in the forward direction `irq` is high exactly when count <= T.
- R8: Any threshold field value of 15 or more, including 16, gives an effective threshold T of 15.
- R9: With DMA enabled and the service bit clear, `dma_req` is high when count >= 1 in the reverse direction and when count < 16 in the forward direction. `irq` stays low while DMA is enabled.
- R10: A `tc` pulse sets the service bit. While that bit is set, `irq` and `dma_req` are low. After the host clears the bit, both come back under R6, R7 and R9.
- R11: A push into a full queue or a pop from an empty queue sets a sticky error flag. Writing 1 to bit 7 at offset 0x401 clears the flag, and a new fault in the same cycle wins over the clear.
- R12: A control write that changes the direction bit empties the queue.
- R13: `irq` and `dma_req` are registered. They follow a change of count or control one clock after that change takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 11 | Host register offset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid one clock after the read strobe |
| eng_push | input | 1 | Engine push strobe (reverse direction) |
| eng_push_data | input | 8 | Byte pushed by the engine |
| eng_pop | input | 1 | Engine pop strobe (forward direction) |
| eng_pop_data | output | 8 | Popped byte, valid one clock after the pop |
| eng_pop_tag | output | 1 | Tag of the popped byte |
| tc | input | 1 | Terminal-count pulse from the DMA controller |
| irq | output | 1 | Programmed I/O service request |
| dma_req | output | 1 | DMA service request |

## Verification
The checks assume that the host drives at most one strobe per cycle, never `host_rd` together with `host_wr`. They also assume that `tc` never coincides with a control write. With these in place, the service-bit and sticky-error properties relate one clean cycle to the next. The stimulus keeps within these assumptions by issuing one operation per task call. Each task holds its strobes for exactly one edge and then idles. Engine strobes, host strobes and `tc` pulses are never overlapped, including in the random phase.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

  localparam int unsigned ADDR_W = 11;
  localparam int unsigned BYTE_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CMD  = 11'h000;
  localparam logic [ADDR_W-1:0] OFS_DATA = 11'h400;
  localparam logic [ADDR_W-1:0] OFS_STAT = 11'h401;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 11'h402;

  // control byte: [7:3] threshold, [2] service, [1] dma enable, [0] reverse
  typedef struct packed {
    logic [4:0] thr;
    logic       svc;
    logic       dma_en;
    logic       rev;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{thr: 5'd0, svc: 1'b1, dma_en: 1'b0, rev: 1'b0};

  typedef enum logic [1:0] {
    RS_NONE,
    RS_DATA,
    RS_HOLD
  } rsel_e;

endpackage

// File: rtl/ppf_store.sv
module ppf_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 9
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 push_word,
  input  logic                         pop,
  output logic [W-1:0]                 pop_word,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic                         full,
  output logic                         empty,
  output logic                         push_ok,
  output logic                         pop_ok
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rd_q;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // storage array without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_q <= '0;
    else if (pop_ok) rd_q <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt      = cnt_q;
  assign pop_word = rd_q;

endmodule

// File: rtl/ppf_req.sv
module ppf_req
  import ppf_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(DEPTH+1)-1:0] cnt,
  input  ctrl_t                      ctrl,
  output logic                       irq,
  output logic                       dma_req
);

  localparam int unsigned TMAX = DEPTH - 1;

  int unsigned eff_thr, occ;
  logic        rev_hit, fwd_hit, dma_hit, irq_d, dma_d;
  logic        irq_q, dma_q;

  always_comb begin
    occ     = 32'(cnt);
    eff_thr = (32'(ctrl.thr) > TMAX) ? TMAX : 32'(ctrl.thr);
    rev_hit = (occ >= DEPTH - eff_thr);
    fwd_hit = (occ <= eff_thr);
    dma_hit = ctrl.rev ? (occ >= 1) : (occ < DEPTH);
    irq_d   = !ctrl.dma_en && !ctrl.svc && (ctrl.rev ? rev_hit : fwd_hit);
    dma_d   = ctrl.dma_en && !ctrl.svc && dma_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      dma_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      dma_q <= dma_d;
    end
  end

  assign irq     = irq_q;
  assign dma_req = dma_q;

endmodule

// File: rtl/ppf_regs.sv
module ppf_regs
  import ppf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [BYTE_W-1:0] ctrl_wdata,
  input  logic              err_clr,
  input  logic              fault,
  input  logic              tc,
  output ctrl_t             ctrl,
  output logic              err,
  output logic              flush
);

  ctrl_t ctrl_q;
  logic  err_q;

  assign flush = ctrl_we && (ctrl_wdata[0] != ctrl_q.rev);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      err_q  <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_t'(ctrl_wdata);
      if (tc)      ctrl_q.svc <= 1'b1;
      if (fault)        err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  assign ctrl = ctrl_q;
  assign err  = err_q;

endmodule

// File: rtl/ppfifo_ctl.sv
module ppfifo_ctl
  import ppf_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [10:0]       host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              eng_push,
  input  logic [7:0]        eng_push_data,
  input  logic              eng_pop,
  output logic [7:0]        eng_pop_data,
  output logic              eng_pop_tag,
  input  logic              tc,
  output logic              irq,
  output logic              dma_req
);

  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned WW = BYTE_W + 1;

  ctrl_t          ctrl;
  logic           err, err_clr, flush, fault;
  logic           svc_bit, dma_bit;
  logic           wr_cmd, wr_data, rd_data, ctrl_we;
  logic           push, pop, push_ok, pop_ok, full, empty;
  logic [WW-1:0]  push_word, pop_word;
  logic [CW-1:0]  cnt;
  logic [7:0]     stat_byte;
  rsel_e          rsel_q;
  logic [7:0]     hold_q;

  // host decode
  assign wr_cmd  = host_wr && (host_addr == OFS_CMD);
  assign wr_data = host_wr && (host_addr == OFS_DATA);
  assign rd_data = host_rd && (host_addr == OFS_DATA);
  assign ctrl_we = host_wr && (host_addr == OFS_CTRL);
  assign err_clr = host_wr && (host_addr == OFS_STAT) && host_wdata[7];

  // side selection by direction
  assign push      = ctrl.rev ? eng_push : (wr_cmd || wr_data);
  assign push_word = ctrl.rev ? {1'b0, eng_push_data} : {wr_cmd, host_wdata};
  assign pop       = ctrl.rev ? rd_data : eng_pop;
  assign fault     = !flush && ((push && full) || (pop && empty));

  assign svc_bit   = ctrl.svc;
  assign dma_bit   = ctrl.dma_en;
  assign stat_byte = {err, full, empty, 5'(cnt)};

  ppf_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (host_wdata),
    .err_clr    (err_clr),
    .fault      (fault),
    .tc         (tc),
    .ctrl       (ctrl),
    .err        (err),
    .flush      (flush)
  );

  ppf_store #(.DEPTH(DEPTH), .W(WW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .push      (push),
    .push_word (push_word),
    .pop       (pop),
    .pop_word  (pop_word),
    .cnt       (cnt),
    .full      (full),
    .empty     (empty),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok)
  );

  ppf_req #(.DEPTH(DEPTH)) u_req (
    .clk     (clk),
    .rst     (rst),
    .cnt     (cnt),
    .ctrl    (ctrl),
    .irq     (irq),
    .dma_req (dma_req)
  );

  // registered host read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q <= RS_NONE;
      hold_q <= '0;
    end else if (host_rd) begin
      rsel_q <= RS_HOLD;
      hold_q <= '0;
      case (host_addr)
        OFS_DATA: if (pop_ok && ctrl.rev) rsel_q <= RS_DATA;
        OFS_STAT: hold_q <= stat_byte;
        OFS_CTRL: hold_q <= ctrl;
        default:  hold_q <= '0;
      endcase
    end
  end

  assign host_rdata   = (rsel_q == RS_DATA) ? pop_word[BYTE_W-1:0] : hold_q;
  assign eng_pop_data = pop_word[BYTE_W-1:0];
  assign eng_pop_tag  = pop_word[BYTE_W];

  logic unused_ok;
  assign unused_ok = push_ok;

endmodule

// File: rtl/ppfifo_ctl_chk.sv
module ppfifo_ctl_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          irq,
  input logic          dma_req,
  input logic [CW-1:0] cnt,
  input logic          full,
  input logic          empty,
  input logic          svc,
  input logic          dma_en,
  input logic          tc,
  input logic          err,
  input logic          err_clr
);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) <= DEPTH);  // R1

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));  // R2

  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(irq && dma_req));  // R9

  AST_DMA_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> $past(dma_en));  // R9

  AST_TC_SETS_SVC: assert property (@(posedge clk) disable iff (rst)
    tc |=> svc);  // R10

  AST_SVC_QUIET: assert property (@(posedge clk) disable iff (rst)
    svc |=> (!irq && !dma_req));  // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err && !err_clr) |=> err);  // R11

endmodule

bind ppfifo_ctl ppfifo_ctl_chk #(.DEPTH(DEPTH), .CW($clog2(DEPTH + 1))) u_chk (
  .clk     (clk),
  .rst     (rst),
  .irq     (irq),
  .dma_req (dma_req),
  .cnt     (cnt),
  .full    (full),
  .empty   (empty),
  .svc     (svc_bit),
  .dma_en  (dma_bit),
  .tc      (tc),
  .err     (err),
  .err_clr (err_clr)
);

// File: tb/ppfifo_ctl_tb.sv
module ppfifo_ctl_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [10:0] host_addr;
  logic        host_wr, host_rd;
  logic [7:0]  host_wdata;
  logic [7:0]  host_rdata;
  logic        eng_push, eng_pop, tc;
  logic [7:0]  eng_push_data, eng_pop_data;
  logic        eng_pop_tag, irq, dma_req;

  int n_vec = 0;
  int n_bad = 0;

  logic [8:0] mq [16];
  int         mcnt;
  logic [7:0] mctl;
  bit         merr;

  always #4 clk = ~clk;

  ppfifo_ctl u_dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_push(eng_push), .eng_push_data(eng_push_data), .eng_pop(eng_pop),
    .eng_pop_data(eng_pop_data), .eng_pop_tag(eng_pop_tag), .tc(tc),
    .irq(irq), .dma_req(dma_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit f_irq(input int c, input logic [7:0] cr);
    int e;
    e = (int'(cr[7:3]) > 15) ? 15 : int'(cr[7:3]);
    if (cr[1] || cr[2]) return 1'b0;
    if (cr[0]) return c >= 16 - e;
    return c <= e;
  endfunction

  function automatic bit f_dma(input int c, input logic [7:0] cr);
    if (!cr[1] || cr[2]) return 1'b0;
    return cr[0] ? (c >= 1) : (c < 16);
  endfunction

  task automatic m_push(input logic [8:0] w);
    if (mcnt == 16) merr = 1'b1;
    else begin mq[mcnt] = w; mcnt++; end
  endtask

  task automatic m_pop(output logic [8:0] w, output bit ok);
    ok = (mcnt > 0);
    w = '0;
    if (!ok) merr = 1'b1;
    else begin
      w = mq[0];
      for (int i = 0; i < 15; i++) mq[i] = mq[i+1];
      mcnt--;
    end
  endtask

  task automatic clear_in;
    host_wr = 0; host_rd = 0; eng_push = 0; eng_pop = 0; tc = 0;
  endtask

  task automatic hw(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); clear_in();
    if (a == 11'h402) begin
      if (d[0] != mctl[0]) mcnt = 0;
      mctl = d;
    end else if (a == 11'h401) begin
      if (d[7]) merr = 1'b0;
    end else if ((a == 11'h400 || a == 11'h000) && !mctl[0]) begin
      m_push({a == 11'h000, d});
    end
  endtask

  task automatic hr(input logic [10:0] a, input string req);
    logic [7:0] exp;
    logic [8:0] w;
    bit ok;
    exp = 8'h00;
    if (a == 11'h401) exp = {merr, mcnt == 16, mcnt == 0, 5'(mcnt)};
    else if (a == 11'h402) exp = mctl;
    else if (a == 11'h400 && mctl[0]) begin
      m_pop(w, ok);
      exp = ok ? w[7:0] : 8'h00;
    end
    @(negedge clk); host_addr = a; host_rd = 1;
    @(negedge clk); clear_in();
    chk(req, host_rdata, exp);
  endtask

  task automatic ep_push(input logic [7:0] d);
    @(negedge clk); eng_push = 1; eng_push_data = d;
    @(negedge clk); clear_in();
    if (mctl[0]) m_push({1'b0, d});
  endtask

  task automatic ep_pop(input string req);
    logic [8:0] w;
    bit ok;
    @(negedge clk); eng_pop = 1;
    @(negedge clk); clear_in();
    if (!mctl[0]) begin
      m_pop(w, ok);
      if (ok) chk(req, {eng_pop_tag, eng_pop_data}, w);
    end
  endtask

  task automatic tc_pulse;
    @(negedge clk); tc = 1;
    @(negedge clk); clear_in();
    mctl[2] = 1'b1;
  endtask

  task automatic chk_req(input string req);
    @(negedge clk);
    chk(req, irq, f_irq(mcnt, mctl));
    chk(req, dma_req, f_dma(mcnt, mctl));
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] thr_list [6];
    bit pre;
    thr_list = '{8'd0, 8'd3, 8'd12, 8'd15, 8'd16, 8'd31};
    void'($urandom(32'd2024));
    clear_in(); host_addr = '0; host_wdata = '0; eng_push_data = '0;
    mcnt = 0; mctl = 8'h04; merr = 1'b0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;

    // reset state
    chk("R3 irq after reset", irq, 1'b0);
    chk("R3 dma_req after reset", dma_req, 1'b0);
    hr(11'h401, "R2 reset status");
    hr(11'h402, "R3 reset control");

    // forward fill with tag mix, overflow, drain, underflow
    hw(11'h402, {5'd12, 3'b000}); chk_req("R7");
    for (int i = 0; i < 16; i++) begin
      hw((i % 2) ? 11'h000 : 11'h400, 8'(8'h30 + i));
      chk_req("R7 fill");
    end
    hr(11'h401, "R2 full status");
    hw(11'h400, 8'hEE);
    hr(11'h401, "R11 overflow sets error");
    hr(11'h400, "R4 host read forward returns 0");
    for (int i = 0; i < 16; i++) ep_pop("R1 R4 order and tag");
    ep_pop("R11 underflow");
    hr(11'h401, "R11 error sticky");
    hw(11'h401, 8'h80);
    hr(11'h401, "R11 error cleared");

    // registered request timing
    hw(11'h402, 8'h00); chk_req("R13");
    pre = irq;
    hw(11'h400, 8'h5A);
    chk("R13 irq unchanged one clock after push", irq, pre);
    chk_req("R13 irq after second clock");
    ep_pop("R4");

    // direction change flushes
    hw(11'h400, 8'h01); hw(11'h400, 8'h02); hw(11'h400, 8'h03);
    hw(11'h402, 8'h01);
    hr(11'h401, "R12 flush on direction change");
    ep_pop("R5 engine pop ignored in reverse");
    hr(11'h401, "R5 status after ignored pop");

    // threshold sweep in both directions
    for (int dir = 1; dir >= 0; dir--) begin
      for (int k = 0; k < 6; k++) begin
        hw(11'h402, {thr_list[k][4:0], 2'b00, 1'(dir)});
        chk_req(thr_list[k] >= 15 ? "R8" : (dir ? "R6" : "R7"));
        for (int i = 0; i < 16; i++) begin
          if (dir) ep_push(8'($urandom_range(0, 255)));
          else hw(($urandom_range(0, 1) != 0) ? 11'h000 : 11'h400, 8'($urandom_range(0, 255)));
          chk_req(thr_list[k] >= 15 ? "R8 fill" : (dir ? "R6 fill" : "R7 fill"));
        end
        for (int i = 0; i < 16; i++) begin
          if (dir) hr(11'h400, "R5 host pop");
          else ep_pop("R4 engine pop");
          chk_req(thr_list[k] >= 15 ? "R8 drain" : (dir ? "R6 drain" : "R7 drain"));
        end
      end
    end

    // DMA request and terminal count
    hw(11'h402, 8'h03); chk_req("R9 empty");
    ep_push(8'hA1); chk_req("R9 one byte");
    tc_pulse(); chk_req("R10 tc drops request");
    hr(11'h402, "R10 service bit set");
    ep_push(8'hA2); chk_req("R10 still quiet");
    hw(11'h402, 8'h03); chk_req("R10 request returns");
    hw(11'h402, 8'h02); chk_req("R9 forward not full");
    for (int i = 0; i < 16; i++) begin
      hw(11'h400, 8'(i)); chk_req("R9 forward fill");
    end
    hw(11'h402, 8'h66); chk_req("R10 service bit in PIO");
    hw(11'h402, 8'h60); chk_req("R7 after service clear");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 99);
      if (k < 18)      hw(11'h400, 8'($urandom_range(0, 255)));
      else if (k < 26) hw(11'h000, 8'($urandom_range(0, 255)));
      else if (k < 42) hr(11'h400, "R4 R5 random read");
      else if (k < 58) ep_push(8'($urandom_range(0, 255)));
      else if (k < 74) ep_pop("R1 R4 random pop");
      else if (k < 80) hr(11'h401, "R2 R11 random status");
      else if (k < 83) hw(11'h402, {5'($urandom_range(0, 31)), ($urandom_range(0, 3) == 0),
                                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1))});
      else if (k < 86) tc_pulse();
      else if (k < 88) hw(11'h401, 8'h80);
      else if (k < 90) hr(11'h402, "R3 random control");
      else             hw(11'h402, {5'($urandom_range(0, 31)), ($urandom_range(0, 3) == 0),
                                    1'($urandom_range(0, 1)), mctl[0]});
      chk_req("R6 R7 R9 R10 R12 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule